// File: doc/BRIEF.md
# Iterative Shift-Add Sigmoid Unit

This unit returns the logistic sigmoid of one signed fixed-point sample. It uses no multipliers, only shifts, adds and compares. The input is halved, and its magnitude is reduced by whole multiples of ln 2. Hyperbolic-rotation CORDIC then turns the remainder into a scaled cosh/sinh pair. The pair is recombined with the removed power of two, which is applied as a shift. A restoring shift-subtract divider forms tanh of the half input. The final value is one half plus or minus half of that quotient, with the sign taken from the input.

One sample is handled at a time. A sample is taken when the unit shows it is ready and the producer marks the sample valid. Readiness then drops until the result has been handed out. The result is handed out with a one-cycle valid strobe. Very large magnitudes skip the iterative work and return the output rail directly.

Top module: `cordic_sigmoid`

## Requirements
- R1: A sample is captured on a rising edge where `in_valid` and `in_ready` are both 1; `in_ready` reads 0 from the next cycle until the result has been handed out.
- R2: `in_valid` asserted while `in_ready` is 0 is ignored: it starts no computation, it does not change the pending result, and it produces no extra `out_valid` pulse.
- R3: Each result is presented with `out_valid` high for exactly one cycle, and `in_ready` is 1 in the cycle after that pulse.
- R4: `out_data` is unsigned in effect, has W bits and W-2 fraction bits, and lies within 2 LSB of sigmoid(x), where x is `in_data` read as two's complement with F fraction bits.
- R5: The rotation phase and the division phase each run N = max(W-1, 7) iterations, one per cycle. The rotation index sequence starts at 1, and indices 4, 13 and 40 are each used twice. For inputs with |x|/2 below ln 2, `out_valid` rises 2N+1 cycles after the capture edge.
- R6: Inputs with |x|/2 of ln 2 or more are range-reduced by whole multiples of ln 2, and they meet the R4 accuracy across the whole input range.
- R7: When |x|/2 reaches QS·ln 2, with QS = floor((W+1)/2), the output is exactly 0 for negative x and exactly 2^(W-2)-1 for positive x. No output ever exceeds 2^(W-2)-1, so the top bit is always 0.
- R8: Across consecutive input codes in signed order, the output never falls by more than 1 LSB, and it never wraps at either end of the range.
- R9: While the synchronous active-high `rst` is held, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | W | Signed sample, F fraction bits |
| in_valid | input | 1 | Sample on `in_data` is offered |
| in_ready | output | 1 | Unit is idle and will take a sample |
| out_data | output | W | Sigmoid result, W-2 fraction bits |
| out_valid | output | 1 | One-cycle strobe marking `out_data` |

## Verification
A 10-bit configuration with 6 fraction bits is swept over every input code in signed order. Each result is compared against a real-valued sigmoid. Codes near zero separate the plain rotation path from the range-reduced path, and their latency must match the fixed iteration count. Codes at the ends must hit the exact rails, which separates saturation from the computed path and exposes any wraparound. Every fourth sample is hit with stray valid pulses while the unit is busy, and the strobe and readiness timing is checked around every result.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RED,
    S_ROT,
    S_DIV,
    S_OUT
  } sgm_state_e;

  // Rotation and division iteration count for a given word length.
  function automatic int sgm_iters(input int w);
    return (w - 1 < 7) ? 7 : w - 1;
  endfunction

  // Number of ln2 reductions after which the output is pinned to a rail.
  function automatic int sgm_sat_steps(input int of);
    return (of + 3) / 2;
  endfunction

  // Indices of the hyperbolic sequence that are applied twice.
  function automatic bit sgm_is_rep(input int idx);
    return (idx == 4) || (idx == 13) || (idx == 40);
  endfunction

  // atanh(2^-i) scaled by 2^fr, from its odd power series at 60-bit scale.
  function automatic longint sgm_atanh_fx(input int i, input int fr);
    longint acc;
    int     e;
    acc = 0;
    if (i <= 0) return 0;
    for (int k = 0; k < 64; k++) begin
      e = 60 - i * (2 * k + 1);
      if (e >= 0) acc += (64'sd1 <<< e) / longint'(2 * k + 1);
    end
    return (acc + (64'sd1 <<< (59 - fr))) >>> (60 - fr);
  endfunction

  // ln 2 = 2*atanh(1/3), scaled by 2^fr.
  function automatic longint sgm_ln2_fx(input int fr);
    longint acc;
    longint t;
    acc = 0;
    t   = (64'sd1 <<< 60) / 3;
    for (int k = 0; k < 40; k++) begin
      acc += t / longint'(2 * k + 1);
      t = t / 9;
    end
    return ((2 * acc) + (64'sd1 <<< (59 - fr))) >>> (60 - fr);
  endfunction

endpackage

// File: rtl/sgm_atanh_rom.sv
module sgm_atanh_rom
  import sgm_pkg::*;
#(
  parameter int ZW    = 25,
  parameter int FR    = 18,
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic [IW-1:0] idx,
  output logic [ZW-1:0] ang
);

  logic [ZW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = ZW'(sgm_atanh_fx(g, FR));
  end

  always_comb begin
    ang = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (idx == IW'(k)) ang = tbl[k];
    end
  end

endmodule

// File: rtl/sgm_hyp_step.sv
module sgm_hyp_step #(
  parameter int XW = 21,
  parameter int ZW = 25,
  parameter int SW = 4
) (
  input  logic signed [XW-1:0] x,
  input  logic signed [XW-1:0] y,
  input  logic signed [ZW-1:0] z,
  input  logic        [SW-1:0] sh,
  input  logic        [ZW-1:0] ang,
  output logic signed [XW-1:0] x_n,
  output logic signed [XW-1:0] y_n,
  output logic signed [ZW-1:0] z_n
);

  logic signed [XW-1:0] xs;
  logic signed [XW-1:0] ys;
  logic                 up;

  assign xs  = x >>> sh;
  assign ys  = y >>> sh;
  assign up  = !z[ZW-1];
  assign x_n = up ? x + ys : x - ys;
  assign y_n = up ? y + xs : y - xs;
  assign z_n = up ? z - $signed(ang) : z + $signed(ang);

endmodule

// File: rtl/sgm_div_step.sv
module sgm_div_step #(
  parameter int DW = 40
) (
  input  logic [DW-1:0] rem,
  input  logic [DW-1:0] den,
  output logic [DW-1:0] rem_n,
  output logic          qbit
);

  logic [DW-1:0] dbl;

  assign dbl   = rem << 1;
  assign qbit  = (dbl >= den);
  assign rem_n = qbit ? dbl - den : dbl;

endmodule

// File: rtl/cordic_sigmoid.sv
module cordic_sigmoid
  import sgm_pkg::*;
#(
  parameter int W = 16,
  parameter int F = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid
);

  localparam int N    = sgm_iters(W);
  localparam int OF   = W - 2;
  localparam int FR   = W + 2;
  localparam int QSAT = sgm_sat_steps(OF);
  localparam int ZW   = W + FR - F + 1;
  localparam int XW   = FR + 3;
  localparam int DW   = FR + 2 * QSAT + 4;
  localparam int IW   = $clog2(N + 1);
  localparam int CW   = $clog2(N + 1);
  localparam int QW   = $clog2(QSAT + 1);
  localparam int TS   = N + 1 - OF;
  localparam logic [W-1:0]         MAXB = W'((1 << OF) - 1);
  localparam logic [ZW-1:0]        LN2  = ZW'(sgm_ln2_fx(FR));
  localparam logic signed [XW-1:0] ONE  = {3'b001, {FR{1'b0}}};

  sgm_state_e           st;
  logic                 neg;
  logic [ZW-1:0]        zr;
  logic [QW-1:0]        q;
  logic signed [XW-1:0] xr, yr;
  logic [IW-1:0]        idx;
  logic                 rep_done;
  logic [CW-1:0]        cnt;
  logic [DW-1:0]        rem, den;
  logic [N-1:0]         quo;
  logic [W-1:0]         res;

  // Named events for the checker.
  logic accept, rot_busy, red_sat, red_ge, rot_last, div_last;

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_OUT);
  assign out_data  = res;
  assign accept    = in_valid && in_ready;
  assign rot_busy  = (st == S_ROT);
  assign red_sat   = (st == S_RED) && (q == QW'(QSAT));
  assign red_ge    = (zr >= LN2);
  assign rot_last  = rot_busy && (cnt == CW'(N - 1));
  assign div_last  = (st == S_DIV) && (cnt == CW'(N - 1));

  // Magnitude of the halved input at FR fraction bits.
  logic signed [W:0] u_ext;
  logic [W:0]        u_mag;
  logic [ZW-1:0]     zin;
  assign u_ext = {in_data[W-1], in_data};
  assign u_mag = in_data[W-1] ? -u_ext : u_ext;
  assign zin   = ZW'(u_mag) << (FR - F - 1);

  // Hyperbolic micro-rotation.
  logic [ZW-1:0]        ang;
  logic signed [XW-1:0] xn, yn;
  logic signed [ZW-1:0] zn;

  sgm_atanh_rom #(.ZW(ZW), .FR(FR), .DEPTH(N + 1), .IW(IW)) u_rom (
    .idx (idx),
    .ang (ang)
  );

  sgm_hyp_step #(.XW(XW), .ZW(ZW), .SW(IW)) u_hyp (
    .x   (xr),
    .y   (yr),
    .z   ($signed(zr)),
    .sh  (idx),
    .ang (ang),
    .x_n (xn),
    .y_n (yn),
    .z_n (zn)
  );

  // Recombine e^r and e^-r with the removed power of two.
  logic [XW-1:0] psum, ndif;
  logic [DW-1:0] pw, nw, num0, den0;
  assign psum = xn + yn;
  assign ndif = xn - yn;
  assign pw   = {{(DW - XW){1'b0}}, psum} << {q, 1'b0};
  assign nw   = {{(DW - XW){1'b0}}, ndif};
  assign num0 = (pw > nw) ? pw - nw : '0;
  assign den0 = pw + nw;

  // Shift-subtract division.
  logic [DW-1:0] rem_n;
  logic          qb;
  logic [N-1:0]  quo_n;

  sgm_div_step #(.DW(DW)) u_div (
    .rem   (rem),
    .den   (den),
    .rem_n (rem_n),
    .qbit  (qb)
  );

  assign quo_n = {quo[N-2:0], qb};

  // 1/2 +/- tanh/2, rounded to OF fraction bits, capped below one.
  function automatic logic [W-1:0] map_out(input logic [N-1:0] qv, input logic ng);
    logic [N:0] r;
    logic [W:0] th;
    logic [W:0] s;
    r  = {1'b0, qv} + ((N + 1)'(1) << (TS - 1));
    th = (W + 1)'(r >> TS);
    if (ng) s = (W + 1)'(1 << (OF - 1)) - th;
    else    s = (W + 1)'(1 << (OF - 1)) + th;
    if (s > (W + 1)'(MAXB)) s = (W + 1)'(MAXB);
    return s[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      neg      <= 1'b0;
      zr       <= '0;
      q        <= '0;
      xr       <= '0;
      yr       <= '0;
      idx      <= '0;
      rep_done <= 1'b0;
      cnt      <= '0;
      rem      <= '0;
      den      <= '0;
      quo      <= '0;
      res      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            st  <= S_RED;
            zr  <= zin;
            neg <= in_data[W-1];
            q   <= '0;
          end
        end
        S_RED: begin
          if (red_sat) begin
            res <= neg ? '0 : MAXB;
            st  <= S_OUT;
          end else if (red_ge) begin
            zr <= zr - LN2;
            q  <= q + QW'(1);
          end else begin
            st       <= S_ROT;
            xr       <= ONE;
            yr       <= '0;
            idx      <= IW'(1);
            rep_done <= 1'b0;
            cnt      <= '0;
          end
        end
        S_ROT: begin
          xr  <= xn;
          yr  <= yn;
          zr  <= zn;
          cnt <= cnt + CW'(1);
          if (sgm_is_rep(int'(idx)) && !rep_done) begin
            rep_done <= 1'b1;
          end else begin
            idx      <= idx + IW'(1);
            rep_done <= 1'b0;
          end
          if (rot_last) begin
            st  <= S_DIV;
            rem <= num0;
            den <= den0;
            quo <= '0;
            cnt <= '0;
          end
        end
        S_DIV: begin
          rem <= rem_n;
          quo <= quo_n;
          cnt <= cnt + CW'(1);
          if (div_last) begin
            res <= map_out(quo_n, neg);
            st  <= S_OUT;
          end
        end
        S_OUT:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgm_checker.sv
module sgm_checker #(
  parameter int W  = 16,
  parameter int N  = 15,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          accept,
  input logic          rot_busy,
  input logic [CW-1:0] iter_cnt
);

  localparam logic [W-1:0] MAXB = W'((1 << (W - 2)) - 1);

  p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_ready_after_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> in_ready);

  p_busy_on_out_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_iter_bound_r5: assert property (@(posedge clk) disable iff (rst)
    rot_busy |-> (iter_cnt <= CW'(N - 1)));

  p_out_rail_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data <= MAXB));

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

endmodule

bind cordic_sigmoid sgm_checker #(.W(W), .N(N), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .accept    (accept),
  .rot_busy  (rot_busy),
  .iter_cnt  (cnt)
);

// File: tb/tb_cordic_sigmoid.sv
`timescale 1ns/1ps
module tb_cordic_sigmoid;

  localparam int TW   = 10;
  localparam int TF   = 6;
  localparam int TOF  = TW - 2;
  localparam int NIT  = (TW - 1 < 7) ? 7 : TW - 1;
  localparam int TMAX = (1 << TOF) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [TW-1:0] in_data;
  logic          in_valid;
  logic          in_ready;
  logic [TW-1:0] out_data;
  logic          out_valid;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  cordic_sigmoid #(.W(TW), .F(TF)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic real in_real(input logic [TW-1:0] v);
    return $itor($signed(v)) / (2.0 ** TF);
  endfunction

  function automatic int exp_code(input logic [TW-1:0] v);
    real s;
    int  c;
    s = (1.0 / (1.0 + $exp(-in_real(v)))) * (2.0 ** TOF);
    c = $rtoi(s + 0.5);
    if (c > TMAX) c = TMAX;
    if (c < 0) c = 0;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run_one(input logic [TW-1:0] v, input bit inject,
                         output logic [TW-1:0] r, output int lat);
    int guard;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data  = v;
    in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R1 ready low after capture", int'(in_ready), 0);
    in_valid = 1'b0;
    lat      = 0;
    guard    = 0;
    while (!out_valid && guard < 1000) begin
      if (inject && lat == 1) begin
        in_valid = 1'b1;
        in_data  = ~v;
      end
      if (inject && lat == 3) in_valid = 1'b0;
      @(negedge clk);
      lat++;
      guard++;
    end
    r = out_data;
    check(out_valid == 1'b1, "R3 result strobe seen", int'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R3 strobe lasts one cycle", int'(out_valid), 0);
    check(in_ready == 1'b1, "R3 ready after strobe", int'(in_ready), 1);
    if (inject) begin
      int extra;
      extra = 0;
      repeat (3) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      check(extra == 0, "R2 busy-time valid ignored", extra, 0);
    end
  endtask

  initial begin
    logic [TW-1:0] r;
    int            lat;
    int            e;
    int            diff;
    int            prev;
    real           ua;
    rst      = 1'b1;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R9 ready in reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R9 no strobe in reset", int'(out_valid), 0);
    rst = 1'b0;
    prev = 0;
    for (int i = -(1 << (TW - 1)); i < (1 << (TW - 1)); i++) begin
      logic [TW-1:0] v;
      v = TW'(i);
      run_one(v, (i % 4) == 0, r, lat);
      e    = exp_code(v);
      diff = int'(r) - e;
      if (diff < 0) diff = -diff;
      ua = in_real(v);
      if (ua < 0.0) ua = -ua;
      if (ua > 1.4) check(diff <= 2, "R6 reduced-range value", int'(r), e);
      else          check(diff <= 2, "R4 sigmoid value", int'(r), e);
      check(int'(r) <= TMAX, "R7 output below one", int'(r), TMAX);
      if (ua >= 7.0) check(int'(r) == ((i < 0) ? 0 : TMAX), "R7 saturation rail",
                           int'(r), (i < 0) ? 0 : TMAX);
      if (ua < 1.3) check(lat == 2 * NIT + 1, "R5 iteration latency", lat, 2 * NIT + 1);
      if (i > -(1 << (TW - 1)))
        check(int'(r) + 1 >= prev, "R8 no drop between codes", int'(r), prev);
      prev = int'(r);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule